// File: doc/BRIEF.md
# Reflected CRC-32 Frame Checker

This block runs a CRC-32 over a byte stream at one byte per clock. Bits enter least significant first, and the update uses the bit-reversed form of the generator 0x04C11DB7. A start strobe opens a frame. Each byte is qualified by a valid flag, and an end flag closes the frame. One cycle after the end flag, the block presents two results:

- the finished 32-bit check value, which is the internal register inverted;
- a pass flag, which tells whether the frame carried a correctly appended check value.

A transmitter takes the check value and sends it after the payload, least significant byte first. A receiver feeds the whole frame, including those four bytes, through the same block. A clean frame always leaves the same constant in the register, so the pass flag needs no separate field extraction or compare path.

Top module: `crc32_frame_checker`

## Requirements
- R1: While reset is asserted and after it is released, resultValid is 0, crcOut is 0x00000000 and checkOk is 0 until the first frame end.
- R2: The frame of ASCII bytes "123456789" gives crcOut = 0xCBF43926. The register is preset to all ones, bits are taken LSB first with the reflected polynomial 0xEDB88320, and the output is the register XOR 0xFFFFFFFF.
- R3: resultValid is 1 in exactly the cycle after a cycle with eofIn = 1. crcOut and checkOk change only in that cycle and hold their values until the next frame end.
- R4: sofIn reloads the all-ones preset. A byte presented with sofIn in the same cycle is absorbed into that fresh preset, so bytes seen before the strobe have no effect.
- R5: A payload followed by its own check value, least significant byte first, gives crcOut = 0x2144DF1C and checkOk = 1. The internal register then holds 0xDEBB20E3.
- R6: A frame that does not end on that residue, for example one with a single bit flipped, gives checkOk = 0.
- R7: Appending the inverted check value, low byte first, gives crcOut = 0xFFFFFFFF. For "123456789" these bytes are D9 C6 0B 34. Any number of zero bytes after them keeps crcOut at 0xFFFFFFFF.
- R8: A frame with sofIn and eofIn in one cycle and no valid byte gives crcOut = 0x00000000.
- R9: Frames may follow each other with no idle cycle. The result of one frame is presented while the first byte of the next is absorbed.
- R10: A cycle with dataValid = 0 leaves the register unchanged, whatever is on dataByte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sofIn | input | 1 | Start of frame: reload preset |
| dataValid | input | 1 | dataByte holds a byte to absorb |
| dataByte | input | 8 | Frame byte, bit 0 processed first |
| eofIn | input | 1 | Last cycle of the frame |
| crcOut | output | 32 | Finished check value of the last frame |
| checkOk | output | 1 | Last frame ended on the residue constant |
| resultValid | output | 1 | One-cycle pulse: new crcOut/checkOk |

## Verification
The standard nine-digit string establishes the polynomial, the bit order, the preset and the final inversion. Appending the check value low byte first makes the pass flag fire, and flipping one bit of that frame clears it, which separates a true residue compare from one that ignores the data. Appending the raw register bytes and then zero bytes shows that the register stays at zero, and the empty frame shows the preset/inversion pairing. Frames with garbage before the start strobe, invalid gaps carrying junk data, back-to-back frames, and random frames compared against a bitwise model each clock separate the reload, qualify and pipelining behaviour.

// File: rtl/crc32_frame_pkg.sv
package crc32_frame_pkg;
  // Strobes from the control side to the datapath
  typedef struct packed {
    logic load;    // reload preset before this cycle's byte
    logic absorb;  // fold dataByte into the register
    logic finish;  // capture result at this edge
  } crcStrobe_t;

  localparam logic [31:0] CRC32_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC32_PRESET    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC32_XOR_OUT   = 32'hFFFFFFFF;
  localparam logic [31:0] CRC32_RESIDUE   = 32'hDEBB20E3;
endpackage

// File: rtl/crc32_frame_ctrl.sv
module crc32_frame_ctrl
  import crc32_frame_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sofIn,
  input  logic       dataValid,
  input  logic       eofIn,
  output crcStrobe_t strobes,
  output logic       resultValid
);
  always_comb begin
    strobes.load   = sofIn;
    strobes.absorb = dataValid;
    strobes.finish = eofIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= eofIn;
  end

  // R3: a result pulse follows only a frame end
  a_r3_valid_after_eof: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(eofIn));
endmodule

// File: rtl/crc32_frame_datapath.sv
module crc32_frame_datapath
  import crc32_frame_pkg::*;
#(
  parameter int          CRC_W   = 32,
  parameter int          BYTE_W  = 8,
  parameter logic [31:0] POLY    = CRC32_POLY_REFL,
  parameter logic [31:0] PRESET  = CRC32_PRESET,
  parameter logic [31:0] XOR_OUT = CRC32_XOR_OUT,
  parameter logic [31:0] RESIDUE = CRC32_RESIDUE
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobe_t        strobes,
  input  logic [BYTE_W-1:0] dataByte,
  output logic [CRC_W-1:0]  crcOut,
  output logic              checkOk
);
  localparam logic [CRC_W-1:0] POLY_W    = POLY[CRC_W-1:0];
  localparam logic [CRC_W-1:0] PRESET_W  = PRESET[CRC_W-1:0];
  localparam logic [CRC_W-1:0] XOROUT_W  = XOR_OUT[CRC_W-1:0];
  localparam logic [CRC_W-1:0] RESIDUE_W = RESIDUE[CRC_W-1:0];

  logic [CRC_W-1:0] crcState;
  logic [CRC_W-1:0] nextState;
  logic [CRC_W-1:0] chain [0:BYTE_W];

  assign chain[0] = strobes.load ? PRESET_W : crcState;

  // One shift/conditional-XOR stage per input bit, LSB first
  for (genvar i = 0; i < BYTE_W; i++) begin : g_bitStep
    logic feedBit;
    assign feedBit      = chain[i][0] ^ dataByte[i];
    assign chain[i + 1] = (chain[i] >> 1) ^ (feedBit ? POLY_W : '0);
  end

  assign nextState = strobes.absorb ? chain[BYTE_W] : chain[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcState <= PRESET_W;
      crcOut   <= '0;
      checkOk  <= 1'b0;
    end else begin
      crcState <= nextState;
      if (strobes.finish) begin
        crcOut  <= nextState ^ XOROUT_W;
        checkOk <= (nextState == RESIDUE_W);
      end
    end
  end

  // R4: a bare start strobe leaves the preset in the register
  a_r4_load_preset: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.absorb) |=> crcState == PRESET_W);
  // R10: no byte and no reload keeps the register
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.absorb) |=> $stable(crcState));
  // R3: results hold between frame ends
  a_r3_result_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.finish |=> ($stable(crcOut) && $stable(checkOk)));
  // R5: pass flag only alongside the residue output value
  a_r5_ok_value: assert property (@(posedge clk) disable iff (!rstN)
    checkOk |-> crcOut == (RESIDUE_W ^ XOROUT_W));
  // R8: empty frame yields preset XOR final value
  a_r8_empty_frame: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.finish && !strobes.absorb) |=> crcOut == (PRESET_W ^ XOROUT_W));
endmodule

// File: rtl/crc32_frame_checker.sv
module crc32_frame_checker
  import crc32_frame_pkg::*;
#(
  parameter int CRC_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sofIn,
  input  logic              dataValid,
  input  logic [BYTE_W-1:0] dataByte,
  input  logic              eofIn,
  output logic [CRC_W-1:0]  crcOut,
  output logic              checkOk,
  output logic              resultValid
);
  crcStrobe_t strobes;

  crc32_frame_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sofIn       (sofIn),
    .dataValid   (dataValid),
    .eofIn       (eofIn),
    .strobes     (strobes),
    .resultValid (resultValid)
  );

  crc32_frame_datapath #(
    .CRC_W  (CRC_W),
    .BYTE_W (BYTE_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .dataByte (dataByte),
    .crcOut   (crcOut),
    .checkOk  (checkOk)
  );
endmodule

// File: tb/crc32_frame_checker_test.sv
module crc32_frame_checker_test;
  typedef logic [7:0] byteQ_t[$];

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sofIn = 1'b0, dataValid = 1'b0, eofIn = 1'b0;
  logic [7:0]  dataByte = 8'h00;
  logic [31:0] crcOut;
  logic        checkOk, resultValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  crc32_frame_checker uut (
    .clk(clk), .rstN(rstN), .sofIn(sofIn), .dataValid(dataValid),
    .dataByte(dataByte), .eofIn(eofIn), .crcOut(crcOut),
    .checkOk(checkOk), .resultValid(resultValid)
  );

  // Behavioural reference model
  logic [31:0] mState;
  logic [31:0] mCrc;
  logic        mOk, mValid;

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 32'hFFFFFFFF; mCrc = 0; mOk = 0; mValid = 0;
    end else begin
      if (sofIn) mState = 32'hFFFFFFFF;
      if (dataValid)
        for (int b = 0; b < 8; b++) begin
          if ((mState[0] ^ dataByte[b]) == 1'b1) mState = (mState >> 1) ^ 32'hEDB88320;
          else mState = mState >> 1;
        end
      mValid = eofIn;
      if (eofIn) begin
        mCrc = ~mState;
        mOk  = (mState == 32'hDEBB20E3);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3 resultValid", {31'b0, resultValid}, {31'b0, mValid});
      check("R2 crcOut vs model", crcOut, mCrc);
      check("R6 checkOk vs model", {31'b0, checkOk}, {31'b0, mOk});
    end
  end

  task automatic drive(input logic s, input logic v, input logic [7:0] d, input logic e);
    sofIn = s; dataValid = v; dataByte = d; eofIn = e;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  // gapMask bit i set: insert an invalid junk cycle before byte i
  task automatic sendFrame(input byteQ_t f, input int gapMask);
    for (int i = 0; i < f.size(); i++) begin
      if (i > 0 && i < 32 && gapMask[i]) drive(1'b0, 1'b0, 8'hA5 ^ 8'(i), 1'b0);
      drive(i == 0, 1'b1, f[i], i == f.size() - 1);
    end
  endtask

  function automatic byteQ_t digits();
    byteQ_t q;
    for (int i = 0; i < 9; i++) q.push_back(8'h31 + 8'(i));
    return q;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    byteQ_t f;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 resultValid", {31'b0, resultValid}, 32'd0);
    check("R1 crcOut", crcOut, 32'h0);
    check("R1 checkOk", {31'b0, checkOk}, 32'd0);
    rstN = 1'b1;
    idle();
    check("R1 after release", {31'b0, resultValid}, 32'd0);

    // R2: standard string
    sendFrame(digits(), 0);
    check("R2 check value", crcOut, 32'hCBF43926);
    check("R3 pulse", {31'b0, resultValid}, 32'd1);
    idle();
    check("R3 pulse ends", {31'b0, resultValid}, 32'd0);
    check("R3 value held", crcOut, 32'hCBF43926);

    // R5: appended check value, low byte first
    f = digits(); f.push_back(8'h26); f.push_back(8'h39); f.push_back(8'hF4); f.push_back(8'hCB);
    sendFrame(f, 0);
    check("R5 residue output", crcOut, 32'h2144DF1C);
    check("R5 pass flag", {31'b0, checkOk}, 32'd1);

    // R6: one bit flipped
    f[3] = f[3] ^ 8'h10;
    sendFrame(f, 0);
    check("R6 corrupted fails", {31'b0, checkOk}, 32'd0);
    idle();

    // R7: inverted check value appended, then zeros
    f = digits(); f.push_back(8'hD9); f.push_back(8'hC6); f.push_back(8'h0B); f.push_back(8'h34);
    sendFrame(f, 0);
    check("R7 register zero", crcOut, 32'hFFFFFFFF);
    for (int z = 0; z < 5; z++) f.push_back(8'h00);
    sendFrame(f, 0);
    check("R7 trailing zeros", crcOut, 32'hFFFFFFFF);

    // R8: empty frame
    drive(1'b1, 1'b0, 8'h77, 1'b1);
    check("R8 empty frame", crcOut, 32'h0);
    idle();

    // R4: junk before the start strobe
    for (int j = 0; j < 4; j++) drive(1'b0, 1'b1, 8'h5A + 8'(j), 1'b0);
    sendFrame(digits(), 0);
    check("R4 reload on sof", crcOut, 32'hCBF43926);

    // R10: invalid cycles carrying junk data
    sendFrame(digits(), 32'h1AA);
    check("R10 invalid ignored", crcOut, 32'hCBF43926);

    // R9: back-to-back frames
    f = digits(); f.push_back(8'h26); f.push_back(8'h39); f.push_back(8'hF4); f.push_back(8'hCB);
    sendFrame(digits(), 0);
    check("R9 first frame", crcOut, 32'hCBF43926);
    sendFrame(f, 0);
    check("R9 second frame", crcOut, 32'h2144DF1C);
    check("R9 second pass", {31'b0, checkOk}, 32'd1);

    // Random frames compared by the per-clock model
    for (int n = 0; n < 40; n++) begin
      byteQ_t r;
      int len = 1 + int'($urandom_range(20));
      for (int k = 0; k < len; k++) r.push_back(8'($urandom));
      sendFrame(r, int'($urandom));
      if (($urandom & 1) != 0) idle();
    end
    idle();
    idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule